// File: doc/BRIEF.md
# System Control Coprocessor Register File

This block is the privileged control-register bank that a 32-bit processor core reaches through its coprocessor register-transfer path. Each request carries a primary register number, a secondary selector, two opcode fields, a privilege flag, a read/write direction and 32 bits of write data. Before it touches any state, the block checks whether that exact combination is legal for the addressed register. An illegal request is answered with a reject and changes nothing. A legal one is answered with done: a read returns the register contents, and a write stores the data through a fixed per-register keep mask, with some bits forced to one.

Two banks sit side by side. A zero secondary opcode selects the main bank. Any other value selects an alternate bank, which holds only a cache-type word and an auxiliary control byte. Primary register 14 also reaches four separate full-width debug words, chosen by the secondary selector. Cache, TLB and lockdown operation encodings are accepted with no side effect. A write that flips the byte-order bit of the control register is reported to the core: the new level appears on one output and a one-cycle pulse on another.

Top module: `sysctl_regbank`

## Requirements
- R1: Any request with the privilege flag low, or with a nonzero first opcode field, is rejected and changes no state.
- R2: Primary registers 4, 11 and 12 reject every request.
- R3: Registers 0 and 1 need selector 0 (any second opcode). Registers 2, 3, 5, 6 and 13 need selector 0 and second opcode 0. Register 15 needs second opcode 0 and selector 1.
- R4: Register 7 accepts only the (second opcode, selector) pairs (0,5) (0,6) (0,7) (1,5) (1,6) (1,10) (4,10) (5,2) (6,5). Register 8 accepts second opcode 0 with selector 5, 6 or 7, and second opcode 1 with selector 5 or 6.
- R5: Register 9 accepts second opcode 0 or 1 with selector 1 or 2. Register 10 accepts second opcode 0 or 1 with selector 4 or 8. Register 14 accepts only second opcode 0 with selector 0, 3, 4, 8 or 9.
- R6: Second opcode 0 addresses the main bank and any other value the alternate bank. After reset, main[0] reads 0x69050000, alternate[0] reads 0x0B1AA1AA, main[1] reads 0x00000078 and every other word reads 0. In the alternate bank, entries above 1 read 0.
- R7: Writes to main[0] and alternate[0] are ignored. A write to alternate[1] keeps bits under mask 0x33. A write to main[1] stores (data AND 0x00003B87) OR 0x00000078.
- R8: Keep masks are 0xFFFFC000 for register 2, 0x000006FF for 5, 0x00000001 for 9, 0xFE000000 for 13 and 0x00003FFF for 15. Registers 3 and 6 keep all bits. Writes to 7, 8 and 10 are accepted but store nothing, so those registers read 0.
- R9: On register 14, selectors 3, 4, 8 and 9 each address their own full 32-bit debug word, and selector 0 addresses main[14]. All five are independent.
- R10: Bit 7 of main[1] is the byte-order bit and drives big_endian. A write that changes it raises endian_change for exactly one cycle, together with the response.
- R11: The response appears one clock after the request, with exactly one of rsp_done and rsp_reject high. Nothing is raised for idle cycles. rsp_rdata is 0 except for an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | Core is in a privileged mode |
| req_op1 | input | 3 | First opcode field |
| req_crn | input | 4 | Primary register number |
| req_crm | input | 4 | Secondary register selector |
| req_op2 | input | 3 | Second opcode field (bank select) |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | Previous request accepted |
| rsp_reject | output | 1 | Previous request refused |
| rsp_rdata | output | 32 | Read data of an accepted read |
| endian_change | output | 1 | One-cycle pulse on a byte-order change |
| big_endian | output | 1 | Current byte-order level |

## Verification
A wrong legality decision shows one clock later, as the wrong one of rsp_done and rsp_reject. A wrong keep mask, forced bit or bank choice stays hidden until that register is read again. The read then returns the bad word on the next cycle. For that reason every write in the stimulus is followed by a read-back, and every refused access is followed by a read of the word it could have damaged. A stale or doubled byte-order bit shows at once on big_endian and endian_change, in the same cycle as the write's response.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int DW      = 32;
    localparam int NREG    = 16;
    localparam int NDBG    = 4;
    localparam int AW      = $clog2(NREG);
    localparam int DBG_IW  = $clog2(NDBG);

    // selector codes of the debug words on register 14, in index order
    localparam logic [3:0] DBG_CRM [NDBG] = '{4'd3, 4'd4, 4'd8, 4'd9};

    localparam logic [DW-1:0] KEEP_CTRL  = 32'h0000_3B87;
    localparam logic [DW-1:0] FORCE_CTRL = 32'h0000_0078;
    localparam logic [DW-1:0] KEEP_AUX   = 32'h0000_0033;
    localparam logic [DW-1:0] KEEP_TTB   = 32'hFFFF_C000;
    localparam logic [DW-1:0] KEEP_FSR   = 32'h0000_06FF;
    localparam logic [DW-1:0] KEEP_DLCK  = 32'h0000_0001;
    localparam logic [DW-1:0] KEEP_PID   = 32'hFE00_0000;
    localparam logic [DW-1:0] KEEP_CPAR  = 32'h0000_3FFF;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] bank_a;
        logic [DW-1:0]           aux_b;
        logic [NDBG-1:0][DW-1:0] dbg;
        logic                    done;
        logic                    rej;
        logic [DW-1:0]           rdata;
        logic                    echg;
    } rb_state_t;
endpackage

// File: rtl/sysctl_access_check.sv
module sysctl_access_check (
    input  logic       priv,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output logic       legal
);
    logic ok;

    always_comb begin
        ok = 1'b0;
        case (crn)
            4'd0, 4'd1:
                ok = (crm == 4'd0);
            4'd2, 4'd3, 4'd5, 4'd6, 4'd13:
                ok = (crm == 4'd0) && (op2 == 3'd0);
            4'd7:
                case (op2)
                    3'd0:    ok = (crm == 4'd5) || (crm == 4'd6) || (crm == 4'd7);
                    3'd1:    ok = (crm == 4'd5) || (crm == 4'd6) || (crm == 4'd10);
                    3'd4:    ok = (crm == 4'd10);
                    3'd5:    ok = (crm == 4'd2);
                    3'd6:    ok = (crm == 4'd5);
                    default: ok = 1'b0;
                endcase
            4'd8:
                ok = ((op2 == 3'd0) && (crm >= 4'd5) && (crm <= 4'd7)) ||
                     ((op2 == 3'd1) && ((crm == 4'd5) || (crm == 4'd6)));
            4'd9:
                ok = (op2 <= 3'd1) && ((crm == 4'd1) || (crm == 4'd2));
            4'd10:
                ok = (op2 <= 3'd1) && ((crm == 4'd4) || (crm == 4'd8));
            4'd14:
                ok = (op2 == 3'd0) && ((crm == 4'd0) || (crm == 4'd3) || (crm == 4'd4) ||
                                       (crm == 4'd8) || (crm == 4'd9));
            4'd15:
                ok = (op2 == 3'd0) && (crm == 4'd1);
            default:
                ok = 1'b0;
        endcase
        legal = ok && priv && (op1 == 3'd0);
    end
endmodule

// File: rtl/sysctl_wmask.sv
module sysctl_wmask
    import sysctl_pkg::*;
(
    input  logic [AW-1:0] crn,
    input  logic          alt_bank,
    input  logic [DW-1:0] wdata,
    output logic          store_a,
    output logic          store_b,
    output logic [DW-1:0] wval
);
    logic [DW-1:0] keep;
    logic [DW-1:0] force1;

    always_comb begin
        store_a = 1'b0;
        store_b = 1'b0;
        keep    = '0;
        force1  = '0;
        if (alt_bank) begin
            if (crn == AW'(1)) begin
                store_b = 1'b1;
                keep    = KEEP_AUX;
            end
        end else begin
            case (crn)
                AW'(1):  begin store_a = 1'b1; keep = KEEP_CTRL; force1 = FORCE_CTRL; end
                AW'(2):  begin store_a = 1'b1; keep = KEEP_TTB;  end
                AW'(3),
                AW'(6),
                AW'(14): begin store_a = 1'b1; keep = '1;        end
                AW'(5):  begin store_a = 1'b1; keep = KEEP_FSR;  end
                AW'(9):  begin store_a = 1'b1; keep = KEEP_DLCK; end
                AW'(13): begin store_a = 1'b1; keep = KEEP_PID;  end
                AW'(15): begin store_a = 1'b1; keep = KEEP_CPAR; end
                default: store_a = 1'b0;
            endcase
        end
        wval = (wdata & keep) | force1;
    end
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter logic [31:0] ID_VALUE   = 32'h6905_0000,
    parameter logic [31:0] CACHE_TYPE = 32'h0B1A_A1AA,
    parameter logic [31:0] CTRL_RESET = 32'h0000_0078,
    parameter int          ENDIAN_BIT = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_priv,
    input  logic [2:0]  req_op1,
    input  logic [3:0]  req_crn,
    input  logic [3:0]  req_crm,
    input  logic [2:0]  req_op2,
    input  logic [31:0] req_wdata,
    output logic        rsp_done,
    output logic        rsp_reject,
    output logic [31:0] rsp_rdata,
    output logic        endian_change,
    output logic        big_endian
);
    rb_state_t s_d, s_q;

    logic              legal;
    logic              alt_bank;
    logic              store_a, store_b;
    logic [DW-1:0]     wval;
    logic [NDBG-1:0]   dbg_hit;
    logic              dbg_any;
    logic [DBG_IW-1:0] dbg_idx;
    logic [DW-1:0]     rd_word;

    assign alt_bank = (req_op2 != 3'd0);

    sysctl_access_check u_check (
        .priv  (req_priv),
        .op1   (req_op1),
        .crn   (req_crn),
        .crm   (req_crm),
        .op2   (req_op2),
        .legal (legal)
    );

    sysctl_wmask u_wmask (
        .crn      (req_crn),
        .alt_bank (alt_bank),
        .wdata    (req_wdata),
        .store_a  (store_a),
        .store_b  (store_b),
        .wval     (wval)
    );

    // debug word decode on register 14
    for (genvar g = 0; g < NDBG; g++) begin : g_dbg_hit
        assign dbg_hit[g] = (req_crn == 4'd14) && (req_crm == DBG_CRM[g]);
    end

    always_comb begin
        dbg_any = |dbg_hit;
        dbg_idx = '0;
        for (int i = 0; i < NDBG; i++) begin
            if (dbg_hit[i]) dbg_idx = DBG_IW'(i);
        end
    end

    always_comb begin
        if (alt_bank) begin
            if (req_crn == 4'd0)      rd_word = CACHE_TYPE;
            else if (req_crn == 4'd1) rd_word = s_q.aux_b;
            else                      rd_word = '0;
        end else if (dbg_any) begin
            rd_word = s_q.dbg[dbg_idx];
        end else begin
            rd_word = s_q.bank_a[req_crn];
        end
    end

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.rej   = 1'b0;
        s_d.rdata = '0;
        if (req_valid) begin
            if (!legal) begin
                s_d.rej = 1'b1;
            end else begin
                s_d.done = 1'b1;
                if (!req_write) begin
                    s_d.rdata = rd_word;
                end else if (!alt_bank && dbg_any) begin
                    s_d.dbg[dbg_idx] = req_wdata;
                end else if (store_b) begin
                    s_d.aux_b = wval;
                end else if (store_a) begin
                    s_d.bank_a[req_crn] = wval;
                end
            end
        end
        s_d.echg = s_d.bank_a[1][ENDIAN_BIT] != s_q.bank_a[1][ENDIAN_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.bank_a[0] <= ID_VALUE;
            s_q.bank_a[1] <= CTRL_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_done      = s_q.done;
    assign rsp_reject    = s_q.rej;
    assign rsp_rdata     = s_q.rdata;
    assign endian_change = s_q.echg;
    assign big_endian    = s_q.bank_a[1][ENDIAN_BIT];
endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk #(
    parameter logic [31:0] ID_VALUE = 32'h6905_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic        req_priv,
    input logic [2:0]  req_op1,
    input logic [3:0]  req_crn,
    input logic [3:0]  req_crm,
    input logic [2:0]  req_op2,
    input logic        rsp_done,
    input logic        rsp_reject,
    input logic [31:0] rsp_rdata,
    input logic        endian_change,
    input logic        big_endian
);
    logic ok_fields;
    assign ok_fields = req_valid && req_priv && (req_op1 == 3'd0);

    AST_UNPRIV_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_priv |=> rsp_reject); // R1
    AST_OP1_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_op1 != 3'd0) |=> rsp_reject); // R1
    AST_CLOSED_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_crn == 4'd4 || req_crn == 4'd11 || req_crn == 4'd12) |=> rsp_reject); // R2
    AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> $countones({rsp_done, rsp_reject}) == 1); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_done && !rsp_reject && rsp_rdata == 32'd0); // R11
    AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        ok_fields && !req_write && req_crn == 4'd0 && req_crm == 4'd0 && req_op2 == 3'd0
        |=> rsp_rdata == ID_VALUE); // R7
    AST_CTRL_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        ok_fields && !req_write && req_crn == 4'd1 && req_crm == 4'd0 && req_op2 == 3'd0
        |=> rsp_rdata[6:3] == 4'hF && rsp_rdata[31:14] == 18'd0); // R7
    AST_ENDIAN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        endian_change |-> big_endian != $past(big_endian)); // R10
    AST_ENDIAN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && big_endian != $past(big_endian) |-> endian_change); // R10
endmodule

bind sysctl_regbank sysctl_regbank_chk #(.ID_VALUE(ID_VALUE)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_priv      (req_priv),
    .req_op1       (req_op1),
    .req_crn       (req_crn),
    .req_crm       (req_crm),
    .req_op2       (req_op2),
    .rsp_done      (rsp_done),
    .rsp_reject    (rsp_reject),
    .rsp_rdata     (rsp_rdata),
    .endian_change (endian_change),
    .big_endian    (big_endian)
);

// File: tb/sysctl_regbank_test.sv
module sysctl_regbank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b0;
    logic [2:0]  req_op1 = '0, req_op2 = '0;
    logic [3:0]  req_crn = '0, req_crm = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_done, rsp_reject, endian_change, big_endian;
    logic [31:0] rsp_rdata;

    int errors = 0;
    int checks = 0;
    bit done_run = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    sysctl_regbank uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_priv(req_priv), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
        .req_op2(req_op2), .req_wdata(req_wdata), .rsp_done(rsp_done),
        .rsp_reject(rsp_reject), .rsp_rdata(rsp_rdata),
        .endian_change(endian_change), .big_endian(big_endian)
    );

    typedef struct packed {
        logic        wr;
        logic        priv;
        logic [2:0]  op1;
        logic [3:0]  crn;
        logic [3:0]  crm;
        logic [2:0]  op2;
        logic [31:0] wdata;
        logic        rej;
        logic [31:0] rdata;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 64;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b1,3'd0,4'd0, 4'd0, 3'd0,32'h0,        1'b0,32'h69050000,4'd6},  // R6
        '{1'b0,1'b1,3'd0,4'd0, 4'd0, 3'd1,32'h0,        1'b0,32'h0B1AA1AA,4'd6},  // R6
        '{1'b0,1'b1,3'd0,4'd1, 4'd0, 3'd0,32'h0,        1'b0,32'h00000078,4'd6},  // R6
        '{1'b1,1'b1,3'd0,4'd0, 4'd0, 3'd0,32'hFFFFFFFF, 1'b0,32'h0,       4'd7},  // R7
        '{1'b0,1'b1,3'd0,4'd0, 4'd0, 3'd0,32'h0,        1'b0,32'h69050000,4'd7},  // R7
        '{1'b1,1'b1,3'd0,4'd0, 4'd0, 3'd1,32'hFFFFFFFF, 1'b0,32'h0,       4'd7},  // R7
        '{1'b0,1'b1,3'd0,4'd0, 4'd0, 3'd1,32'h0,        1'b0,32'h0B1AA1AA,4'd7},  // R7
        '{1'b1,1'b1,3'd0,4'd1, 4'd0, 3'd0,32'hFFFFFFFF, 1'b0,32'h0,       4'd7},  // R7
        '{1'b0,1'b1,3'd0,4'd1, 4'd0, 3'd0,32'h0,        1'b0,32'h00003BFF,4'd7},  // R7
        '{1'b1,1'b1,3'd0,4'd1, 4'd0, 3'd0,32'h0,        1'b0,32'h0,       4'd7},  // R7
        '{1'b0,1'b1,3'd0,4'd1, 4'd0, 3'd0,32'h0,        1'b0,32'h00000078,4'd7},  // R7
        '{1'b1,1'b1,3'd0,4'd1, 4'd0, 3'd1,32'hFFFFFFFF, 1'b0,32'h0,       4'd7},  // R7
        '{1'b0,1'b1,3'd0,4'd1, 4'd0, 3'd2,32'h0,        1'b0,32'h00000033,4'd7},  // R7
        '{1'b0,1'b1,3'd0,4'd1, 4'd0, 3'd7,32'h0,        1'b0,32'h00000033,4'd6},  // R6
        '{1'b1,1'b1,3'd0,4'd2, 4'd0, 3'd0,32'h12345678, 1'b0,32'h0,       4'd8},  // R8
        '{1'b0,1'b1,3'd0,4'd2, 4'd0, 3'd0,32'h0,        1'b0,32'h12344000,4'd8},  // R8
        '{1'b1,1'b1,3'd0,4'd2, 4'd0, 3'd1,32'hFFFFFFFF, 1'b1,32'h0,       4'd3},  // R3
        '{1'b1,1'b1,3'd0,4'd5, 4'd0, 3'd0,32'hFFFFFFFF, 1'b0,32'h0,       4'd8},  // R8
        '{1'b0,1'b1,3'd0,4'd5, 4'd0, 3'd0,32'h0,        1'b0,32'h000006FF,4'd8},  // R8
        '{1'b1,1'b1,3'd0,4'd13,4'd0, 3'd0,32'hFFFFFFFF, 1'b0,32'h0,       4'd8},  // R8
        '{1'b0,1'b1,3'd0,4'd13,4'd0, 3'd0,32'h0,        1'b0,32'hFE000000,4'd8},  // R8
        '{1'b1,1'b1,3'd0,4'd15,4'd1, 3'd0,32'hFFFFFFFF, 1'b0,32'h0,       4'd8},  // R8
        '{1'b0,1'b1,3'd0,4'd15,4'd1, 3'd0,32'h0,        1'b0,32'h00003FFF,4'd8},  // R8
        '{1'b0,1'b1,3'd0,4'd15,4'd0, 3'd0,32'h0,        1'b1,32'h0,       4'd3},  // R3
        '{1'b1,1'b1,3'd0,4'd3, 4'd0, 3'd0,32'hA5A5A5A5, 1'b0,32'h0,       4'd8},  // R8
        '{1'b0,1'b1,3'd0,4'd3, 4'd0, 3'd0,32'h0,        1'b0,32'hA5A5A5A5,4'd8},  // R8
        '{1'b1,1'b1,3'd0,4'd6, 4'd0, 3'd0,32'hDEADBEEF, 1'b0,32'h0,       4'd8},  // R8
        '{1'b0,1'b1,3'd0,4'd6, 4'd0, 3'd0,32'h0,        1'b0,32'hDEADBEEF,4'd8},  // R8
        '{1'b0,1'b1,3'd0,4'd0, 4'd1, 3'd0,32'h0,        1'b1,32'h0,       4'd3},  // R3
        '{1'b1,1'b1,3'd0,4'd9, 4'd1, 3'd0,32'hFFFFFFFF, 1'b0,32'h0,       4'd8},  // R8
        '{1'b0,1'b1,3'd0,4'd9, 4'd2, 3'd0,32'h0,        1'b0,32'h00000001,4'd8},  // R8
        '{1'b0,1'b1,3'd0,4'd9, 4'd0, 3'd0,32'h0,        1'b1,32'h0,       4'd5},  // R5
        '{1'b0,1'b1,3'd0,4'd9, 4'd1, 3'd2,32'h0,        1'b1,32'h0,       4'd5},  // R5
        '{1'b0,1'b1,3'd0,4'd9, 4'd1, 3'd1,32'h0,        1'b0,32'h0,       4'd6},  // R6
        '{1'b1,1'b1,3'd0,4'd10,4'd4, 3'd0,32'hFFFFFFFF, 1'b0,32'h0,       4'd8},  // R8
        '{1'b0,1'b1,3'd0,4'd10,4'd8, 3'd0,32'h0,        1'b0,32'h0,       4'd8},  // R8
        '{1'b0,1'b1,3'd0,4'd10,4'd5, 3'd0,32'h0,        1'b1,32'h0,       4'd5},  // R5
        '{1'b1,1'b1,3'd0,4'd7, 4'd5, 3'd0,32'hFFFFFFFF, 1'b0,32'h0,       4'd8},  // R8
        '{1'b0,1'b1,3'd0,4'd7, 4'd10,3'd4,32'h0,        1'b0,32'h0,       4'd4},  // R4
        '{1'b0,1'b1,3'd0,4'd7, 4'd3, 3'd0,32'h0,        1'b1,32'h0,       4'd4},  // R4
        '{1'b0,1'b1,3'd0,4'd7, 4'd2, 3'd5,32'h0,        1'b0,32'h0,       4'd4},  // R4
        '{1'b0,1'b1,3'd0,4'd7, 4'd10,3'd0,32'h0,        1'b1,32'h0,       4'd4},  // R4
        '{1'b0,1'b1,3'd0,4'd7, 4'd5, 3'd6,32'h0,        1'b0,32'h0,       4'd4},  // R4
        '{1'b0,1'b1,3'd0,4'd8, 4'd7, 3'd1,32'h0,        1'b1,32'h0,       4'd4},  // R4
        '{1'b1,1'b1,3'd0,4'd8, 4'd7, 3'd0,32'hFFFFFFFF, 1'b0,32'h0,       4'd4},  // R4
        '{1'b0,1'b1,3'd0,4'd8, 4'd4, 3'd0,32'h0,        1'b1,32'h0,       4'd4},  // R4
        '{1'b1,1'b1,3'd0,4'd14,4'd3, 3'd0,32'h11111111, 1'b0,32'h0,       4'd9},  // R9
        '{1'b1,1'b1,3'd0,4'd14,4'd4, 3'd0,32'h22222222, 1'b0,32'h0,       4'd9},  // R9
        '{1'b1,1'b1,3'd0,4'd14,4'd8, 3'd0,32'h33333333, 1'b0,32'h0,       4'd9},  // R9
        '{1'b1,1'b1,3'd0,4'd14,4'd9, 3'd0,32'h44444444, 1'b0,32'h0,       4'd9},  // R9
        '{1'b1,1'b1,3'd0,4'd14,4'd0, 3'd0,32'h55555555, 1'b0,32'h0,       4'd9},  // R9
        '{1'b0,1'b1,3'd0,4'd14,4'd3, 3'd0,32'h0,        1'b0,32'h11111111,4'd9},  // R9
        '{1'b0,1'b1,3'd0,4'd14,4'd4, 3'd0,32'h0,        1'b0,32'h22222222,4'd9},  // R9
        '{1'b0,1'b1,3'd0,4'd14,4'd8, 3'd0,32'h0,        1'b0,32'h33333333,4'd9},  // R9
        '{1'b0,1'b1,3'd0,4'd14,4'd9, 3'd0,32'h0,        1'b0,32'h44444444,4'd9},  // R9
        '{1'b0,1'b1,3'd0,4'd14,4'd0, 3'd0,32'h0,        1'b0,32'h55555555,4'd9},  // R9
        '{1'b0,1'b1,3'd0,4'd14,4'd1, 3'd0,32'h0,        1'b1,32'h0,       4'd5},  // R5
        '{1'b0,1'b1,3'd0,4'd14,4'd3, 3'd1,32'h0,        1'b1,32'h0,       4'd5},  // R5
        '{1'b0,1'b1,3'd0,4'd4, 4'd0, 3'd0,32'h0,        1'b1,32'h0,       4'd2},  // R2
        '{1'b1,1'b1,3'd0,4'd11,4'd0, 3'd0,32'hFFFFFFFF, 1'b1,32'h0,       4'd2},  // R2
        '{1'b0,1'b1,3'd0,4'd12,4'd0, 3'd0,32'h0,        1'b1,32'h0,       4'd2},  // R2
        '{1'b1,1'b0,3'd0,4'd3, 4'd0, 3'd0,32'h0,        1'b1,32'h0,       4'd1},  // R1
        '{1'b1,1'b1,3'd1,4'd3, 4'd0, 3'd0,32'h0,        1'b1,32'h0,       4'd1},  // R1
        '{1'b0,1'b1,3'd0,4'd3, 4'd0, 3'd0,32'h0,        1'b0,32'hA5A5A5A5,4'd11}  // R11 refused writes left R3 intact
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic [3:0] crn, input logic [3:0] crm,
                         input logic [2:0] op2, input logic [31:0] wd);
        req_valid = 1'b1; req_write = w; req_priv = 1'b1; req_op1 = 3'd0;
        req_crn = crn; req_crm = crm; req_op2 = op2; req_wdata = wd;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R6 R11: reset state at the ports
        check("R11 reset resp", {rsp_done, rsp_reject, rsp_rdata}, 64'd0);
        check("R10 reset endian", {endian_change, big_endian}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 idle quiet", {rsp_done, rsp_reject, rsp_rdata}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            req_valid = 1'b1; req_write = VEC[i].wr; req_priv = VEC[i].priv;
            req_op1 = VEC[i].op1; req_crn = VEC[i].crn; req_crm = VEC[i].crm;
            req_op2 = VEC[i].op2; req_wdata = VEC[i].wdata;
            @(negedge clk);
            checks++;
            if (rsp_done !== !VEC[i].rej || rsp_reject !== VEC[i].rej || rsp_rdata !== VEC[i].rdata) begin
                errors++;
                $display("FAIL R%0d vec %0d actual done=%b rej=%b rdata=%h expected done=%b rej=%b rdata=%h",
                         VEC[i].req, i, rsp_done, rsp_reject, rsp_rdata,
                         !VEC[i].rej, VEC[i].rej, VEC[i].rdata);
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
        check("R11 idle after traffic", {rsp_done, rsp_reject}, 64'd0);

        // R10: byte-order bit changes
        drive(1'b1, 4'd1, 4'd0, 3'd0, 32'h0000_0080);
        @(negedge clk);
        check("R10 pulse on set", {endian_change, big_endian}, 64'd3);
        req_valid = 1'b0;
        @(negedge clk);
        check("R10 pulse one cycle", {endian_change, big_endian}, 64'd1);
        drive(1'b1, 4'd1, 4'd0, 3'd0, 32'h0000_0081);
        @(negedge clk);
        check("R10 no pulse same level", {endian_change, big_endian}, 64'd1);
        drive(1'b1, 4'd1, 4'd0, 3'd1, 32'h0000_0000);
        @(negedge clk);
        check("R10 aux write no pulse", {endian_change, big_endian}, 64'd1);
        drive(1'b1, 4'd1, 4'd0, 3'd0, 32'h0000_0000);
        @(negedge clk);
        check("R10 pulse on clear", {endian_change, big_endian}, 64'd2);
        req_valid = 1'b0;
        @(negedge clk);

        // R6: mid-run reset restores defaults
        drive(1'b1, 4'd1, 4'd0, 3'd1, 32'hFFFF_FFFF);
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        drive(1'b0, 4'd3, 4'd0, 3'd0, 32'h0);
        @(negedge clk);
        check("R6 reg3 cleared", rsp_rdata, 64'd0);
        drive(1'b0, 4'd1, 4'd0, 3'd1, 32'h0);
        @(negedge clk);
        check("R6 aux cleared", rsp_rdata, 64'd0);
        drive(1'b0, 4'd14, 4'd9, 3'd0, 32'h0);
        @(negedge clk);
        check("R9 debug cleared", rsp_rdata, 64'd0);
        drive(1'b0, 4'd1, 4'd0, 3'd0, 32'h0);
        @(negedge clk);
        check("R6 control default", rsp_rdata, 64'h78);
        req_valid = 1'b0;
        @(negedge clk);
        done_run = 1'b1;
    end

    initial begin
        fork
            wait (done_run);
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule